// File: doc/BRIEF.md
# Paired GPIO Port with Edge Interrupt Vectors

This block provides two 8-bit general-purpose I/O ports, a low port and a high port. Software reaches them through a small register bus. A register index picks one register, and two byte enables pick the lanes. Byte lane 0 belongs to the low port and byte lane 1 belongs to the high port, so a write with both enables set updates the paired 16-bit register in one access.

Each pin has these controls: an output value, a direction bit, a pull enable, an interrupt enable and an edge select. Each pin also has a flag bit. Pin inputs pass through a two-flop synchroniser. A synchronised rising or falling edge, as chosen by the edge select, sets the pin's flag. Each port has its own vector register, with no combined 16-bit vector. The vector encodes the lowest-numbered pin that is both flagged and enabled. Reading the vector clears that pin's flag. Each port drives its own interrupt line.

Register indices, one 16-bit slot each: 0 input, 1 output, 2 direction, 3 pull enable, 4 interrupt enable, 5 edge select, 6 flag, 7 low-port vector, 8 high-port vector. Other indices read as zero and ignore writes.

Top module: `gpio_pair_port`

## Requirements
- R1: After reset every register reads zero, `pin_out_o`, `pin_oe_o` and `pin_pull_o` are zero, and `irq_o` is 2'b00.
- R2: A write with `be_i`=2'b11 updates all 16 bits of the addressed register, and a read returns the low port in bits 7:0 and the high port in bits 15:8.
- R3: A write with only `be_i[0]` set changes only the low port's byte. A write with only `be_i[1]` set changes only the high port's byte. A write with `be_i`=2'b00 changes nothing.
- R4: `pin_out_o` equals the output register, `pin_oe_o` equals the direction register (1 = drive), and `pin_pull_o` equals the pull-enable register.
- R5: Index 0 returns the pin levels after the two-flop synchroniser. Writes to index 0 are ignored.
- R6: Edge-select bit 0 picks a rising edge and 1 picks a falling edge. A selected edge sets the pin's flag on the third clock edge after the pin changes, whether or not the interrupt is enabled. Changing the edge select alone sets no flag.
- R7: Software can write the flag register per byte lane to set or clear flags.
- R8: `irq_o[p]` is high exactly when port p has a flag that is both set and enabled.
- R9: A vector read (index 7 for the low port, index 8 for the high port) returns the code in bits 7:0, with bits 15:8 zero. The code is 0 when no enabled flag is pending, and 2*(n+1) for the lowest-numbered pending enabled pin n.
- R10: A vector read clears only the flag it reports and leaves the other port untouched. A new edge on that same pin in the same cycle keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register index |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a vector read clears on the clock edge |
| be_i | input | 2 | Byte enables, bit p selects port p |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational while rd_en_i is high |
| pin_i | input | 16 | Pin levels, asynchronous |
| pin_out_o | output | 16 | Output values |
| pin_oe_o | output | 16 | Output enables |
| pin_pull_o | output | 16 | Pull enables |
| irq_o | output | 2 | Interrupt request per port |

## Verification
A corrupted configuration register appears at once on `pin_out_o`, `pin_oe_o` or `pin_pull_o`, in the cycle after the write. A wrong synchroniser or edge-detect state shows up as a flag that appears one cycle early or late, or under the wrong edge select. That is visible at `irq_o` and in the flag register three cycles after a pin change. A priority or clear fault shows in the sequence of vector codes from repeated reads: a code that repeats or skips a pin exposes it in the very next read. A lane-steering fault shows as a disturbed neighbour byte in the next readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_IN   = 4'd0;
  localparam logic [REG_AW-1:0] A_OUT  = 4'd1;
  localparam logic [REG_AW-1:0] A_DIR  = 4'd2;
  localparam logic [REG_AW-1:0] A_PULL = 4'd3;
  localparam logic [REG_AW-1:0] A_IEN  = 4'd4;
  localparam logic [REG_AW-1:0] A_EDGE = 4'd5;
  localparam logic [REG_AW-1:0] A_FLAG = 4'd6;
  localparam logic [REG_AW-1:0] A_VEC0 = 4'd7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] fall_sel_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // history-based detect: edge select change alone never fires
  assign level_o = s2_q;
  assign edge_o  = (s2_q & ~s3_q & ~fall_sel_i) | (~s2_q & s3_q & fall_sel_i);
endmodule

// File: rtl/gpio_prio_enc.sv
module gpio_prio_enc #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  code_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  assign code_o = valid_o ? W'((32'(idx_o) + 32'd1) * 32'd2) : '0;
endmodule

// File: rtl/gpio_lane.sv
module gpio_lane
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8,
  localparam int IW = (PIN_W > 1) ? $clog2(PIN_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] sel_i,
  input  logic [PIN_W-1:0]  wdata_i,
  input  logic              vec_rd_i,
  input  logic [PIN_W-1:0]  pin_i,
  output logic [PIN_W-1:0]  out_o,
  output logic [PIN_W-1:0]  oe_o,
  output logic [PIN_W-1:0]  pull_o,
  output logic [PIN_W-1:0]  rdata_o,
  output logic [PIN_W-1:0]  vec_o,
  output logic              irq_o
);
  logic [PIN_W-1:0] out_q, dir_q, pull_q, ien_q, fall_q, flag_q, flag_d;
  logic [PIN_W-1:0] level, edge_hit, pend;
  logic             vld;
  logic [IW-1:0]    idx;
  logic             flag_wr;

  gpio_sync #(.W(PIN_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .fall_sel_i (fall_q),
    .level_o    (level),
    .edge_o     (edge_hit)
  );

  assign pend = flag_q & ien_q;

  gpio_prio_enc #(.W(PIN_W)) u_enc (
    .pend_i  (pend),
    .valid_o (vld),
    .idx_o   (idx),
    .code_o  (vec_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      ien_q  <= '0;
      fall_q <= '0;
    end else if (wr_i) begin
      case (sel_i)
        A_OUT:   out_q  <= wdata_i;
        A_DIR:   dir_q  <= wdata_i;
        A_PULL:  pull_q <= wdata_i;
        A_IEN:   ien_q  <= wdata_i;
        A_EDGE:  fall_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign flag_wr = wr_i && (sel_i == A_FLAG);

  // order: software write, vector clear, then edges win
  always_comb begin
    flag_d = flag_q;
    if (flag_wr) flag_d = wdata_i;
    if (vec_rd_i && vld) flag_d[idx] = 1'b0;
    flag_d = flag_d | edge_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  always_comb begin
    case (sel_i)
      A_IN:    rdata_o = level;
      A_OUT:   rdata_o = out_q;
      A_DIR:   rdata_o = dir_q;
      A_PULL:  rdata_o = pull_q;
      A_IEN:   rdata_o = ien_q;
      A_EDGE:  rdata_o = fall_q;
      A_FLAG:  rdata_o = flag_q;
      default: rdata_o = '0;
    endcase
  end

  assign out_o  = out_q;
  assign oe_o   = dir_q;
  assign pull_o = pull_q;
  assign irq_o  = |pend;

  AST_EDGE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_hit) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit))); // R6
  AST_VEC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && vld && !edge_hit[idx] && !flag_wr) |=> !flag_q[$past(idx)]); // R10
  AST_VEC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[0] == 1'b0); // R9
  AST_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (vec_o == '0)); // R9
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> vld); // R8
endmodule

// File: rtl/gpio_pair_port.sv
module gpio_pair_port
  import gpio_pkg::*;
#(
  parameter int PIN_W = 8,
  localparam int NPORT = 2,
  localparam int DW = PIN_W * NPORT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [NPORT-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pin_i,
  output logic [DW-1:0]     pin_out_o,
  output logic [DW-1:0]     pin_oe_o,
  output logic [DW-1:0]     pin_pull_o,
  output logic [NPORT-1:0]  irq_o
);
  logic [DW-1:0]    lane_rd;
  logic [PIN_W-1:0] vec [NPORT];
  logic [NPORT-1:0] vec_hit;
  logic             reg_space;

  assign reg_space = (addr_i < A_VEC0);

  for (genvar p = 0; p < NPORT; p++) begin : g_lane
    localparam logic [REG_AW-1:0] VEC_ADDR = A_VEC0 + REG_AW'(p);
    assign vec_hit[p] = (addr_i == VEC_ADDR);

    gpio_lane #(.PIN_W(PIN_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_en_i && be_i[p] && reg_space),
      .sel_i    (addr_i),
      .wdata_i  (wdata_i[p*PIN_W +: PIN_W]),
      .vec_rd_i (rd_en_i && vec_hit[p]),
      .pin_i    (pin_i[p*PIN_W +: PIN_W]),
      .out_o    (pin_out_o[p*PIN_W +: PIN_W]),
      .oe_o     (pin_oe_o[p*PIN_W +: PIN_W]),
      .pull_o   (pin_pull_o[p*PIN_W +: PIN_W]),
      .rdata_o  (lane_rd[p*PIN_W +: PIN_W]),
      .vec_o    (vec[p]),
      .irq_o    (irq_o[p])
    );
  end

  // vectors are byte-wide per port; no paired vector
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (reg_space) rdata_o = lane_rd;
      for (int p = 0; p < NPORT; p++)
        if (vec_hit[p]) rdata_o = DW'(vec[p]);
    end
  end

  AST_LANE_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && be_i == 2'b01 && addr_i == A_OUT) |=> $stable(pin_out_o[DW-1:PIN_W])); // R3
  AST_IN_READONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IN) |=> ($stable(pin_out_o) && $stable(pin_oe_o) && $stable(pin_pull_o))); // R5
endmodule

// File: tb/sim_gpio_pair_port.sv
module sim_gpio_pair_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0, rdata, pins = '0;
  logic [15:0] pout, poe, ppull;
  logic [1:0]  irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_pair_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .pin_out_o(pout), .pin_oe_o(poe), .pin_pull_o(ppull), .irq_o(irq)
  );

  // {be, wdata, expected output register}
  localparam logic [33:0] TBL [5] = '{
    {2'b11, 16'hA55A, 16'hA55A},
    {2'b01, 16'h00FF, 16'hA5FF},
    {2'b10, 16'h3C00, 16'h3CFF},
    {2'b00, 16'hFFFF, 16'h3CFF},
    {2'b11, 16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 9; a++) rd_chk("R1 reg", 4'(a), 16'h0000);
    chk("R1 outs", pout | poe | ppull, 16'h0000);
    chk("R1 irq", {14'd0, irq}, 16'h0000);

    // R2/R3/R4 table walk on the output register
    for (int i = 0; i < 5; i++) begin
      bus_wr(4'd1, TBL[i][33:32], TBL[i][31:16]);
      chk("R3 pin_out", pout, TBL[i][15:0]);
      rd_chk("R2 readback", 4'd1, TBL[i][15:0]);
    end

    // R4 direction and pull
    bus_wr(4'd2, 2'b11, 16'h0F0F);
    bus_wr(4'd3, 2'b10, 16'hFF00);
    chk("R4 oe", poe, 16'h0F0F);
    chk("R4 pull", ppull, 16'hFF00);

    // R6 rising edges on low port, enable pins 0 and 2
    bus_wr(4'd4, 2'b11, 16'h0005);
    set_pins(16'h0007);
    @(negedge clk);
    chk("R8 irq low", {14'd0, irq}, 16'h0001);
    rd_chk("R6 flags rise", 4'd6, 16'h0007);
    rd_chk("R5 input", 4'd0, 16'h0007);
    rd_chk("R9 vec pin0", 4'd7, 16'h0002);
    rd_chk("R10 vec pin2", 4'd7, 16'h0006);
    rd_chk("R9 vec empty", 4'd7, 16'h0000);
    rd_chk("R10 flag left", 4'd6, 16'h0002);

    // R6 edge select change alone sets nothing
    bus_wr(4'd5, 2'b01, 16'h0002);
    repeat (4) @(posedge clk);
    rd_chk("R6 select only", 4'd6, 16'h0002);
    bus_wr(4'd6, 2'b11, 16'h0000);
    rd_chk("R7 flag clear", 4'd6, 16'h0000);
    set_pins(16'h0004);
    @(negedge clk);
    rd_chk("R6 falling", 4'd6, 16'h0002);
    chk("R8 not enabled", {14'd0, irq}, 16'h0000);

    // high port: pin 7 enabled, pin 1 not
    bus_wr(4'd4, 2'b10, 16'h8000);
    rd_chk("R3 ien", 4'd4, 16'h8005);
    set_pins(16'h8204);
    @(negedge clk);
    rd_chk("R6 high flags", 4'd6, 16'h8202);
    chk("R8 irq high", {14'd0, irq}, 16'h0002);
    rd_chk("R9 low vec idle", 4'd7, 16'h0000);
    rd_chk("R9 vec pin7", 4'd8, 16'h0010);
    rd_chk("R10 clear high", 4'd6, 16'h0202);
    chk("R8 irq drop", {14'd0, irq}, 16'h0000);

    // R7 software set on high lane only
    bus_wr(4'd6, 2'b10, 16'h0100);
    rd_chk("R7 flag set", 4'd6, 16'h0102);

    // R5 input is read-only
    bus_wr(4'd0, 2'b11, 16'hFFFF);
    rd_chk("R5 ignore", 4'd0, 16'h8204);
    chk("R5 outs", pout, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule